// File: doc/BRIEF.md
# Power-Mode Clock Enable Controller

This block tracks whether the chip is running, lightly sleeping or deeply sleeping, and turns that state into clock enables. Each peripheral gets one enable bit. The processor gets one enable. A further request line asks the clock tree for its alternative deep-sleep source. Actual gating cells and clock-source reconfiguration sit outside the block.

Three mask registers hold one enable bit per peripheral, one register for each mode. The processor leaves Run by raising a wait-for-interrupt request, and a deep qualifier sampled with that request picks the target mode. Any interrupt that is both pending and enabled brings the block back to Run.

All enable outputs come straight from flops. A mode change or a mask update therefore reaches the enables only at a clock edge.

Top module: `pgc_top`

## Requirements
- R1: After reset, the mode is Run (encoding 0). The processor enable is 1, the peripheral enables equal the Run mask, and the deep-source request is 0. The reset values of the masks are all ones for Run, all ones for Sleep and all zeros for Deep-Sleep.
- R2: A mask write with `maskWrEn`=1 loads `maskWdata` into one mask chosen by `maskSel`: 0 selects Run, 1 selects Sleep and 2 selects Deep-Sleep. If `maskSel`=3, the write changes no mask. Written data reaches the enables on the second rising edge after the write cycle.
- R3: In Run, `cpuClkEn`=1, `periphClkEn` equals the Run mask, and `deepClkSrcReq`=0.
- R4: In Sleep (encoding 1), `cpuClkEn`=0, `periphClkEn` equals the Sleep mask, and `deepClkSrcReq`=0.
- R5: In Deep-Sleep (encoding 2), `cpuClkEn`=0, `periphClkEn` equals the Deep-Sleep mask, and `deepClkSrcReq`=1.
- R6: In Run, `wfiReq`=1 moves the mode at the next edge. The target is Deep-Sleep when `deepQual`=1 and Sleep otherwise. All enables change at that same edge.
- R7: If `wfiReq` is high in Run while any bit of `irqPend & irqEnable` is set, the mode stays Run.
- R8: In either sleep mode, a nonzero `irqPend & irqEnable` returns the mode to Run at the next edge. Pending interrupts that are not enabled have no effect.
- R9: `wfiReq` raised while already in a sleep mode is ignored. The mode does not switch between Sleep and Deep-Sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| maskWrEn | input | 1 | Mask write strobe |
| maskSel | input | 2 | Mask select (0 Run, 1 Sleep, 2 Deep-Sleep) |
| maskWdata | input | NUM_PERIPH | Mask write data |
| wfiReq | input | 1 | Wait-for-interrupt request from the processor |
| deepQual | input | 1 | Deep-sleep qualifier sampled with `wfiReq` |
| irqPend | input | NUM_IRQ | Pending interrupt lines |
| irqEnable | input | NUM_IRQ | Interrupt enable bits |
| periphClkEn | output | NUM_PERIPH | Registered per-peripheral clock enables |
| cpuClkEn | output | 1 | Registered processor clock enable |
| deepClkSrcReq | output | 1 | Registered request for the deep-sleep clock source |
| modeOut | output | 2 | Current mode (0 Run, 1 Sleep, 2 Deep-Sleep) |

## Verification
Two pairs of functions can coincide in one cycle.

The first pair is a wait-for-interrupt request and an enabled pending interrupt. The bench drives `wfiReq` together with every combination of `irqPend` and `irqEnable`, and expects Run to hold exactly when the AND of the two is nonzero.

The second pair is a mask write and a mode change. The bench writes the mask of the target mode in the same cycle that it requests sleep. It then checks that the first edge shows the old mask and the following edge shows the new one.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_SLEEP = 2'd1,
    MODE_DEEP  = 2'd2
  } pmode_t;

  typedef struct packed {
    pmode_t nextMode;
    logic   sleepEntry;
    logic   wakeEvent;
  } modeStrobe_t;

  localparam int NUM_MODES = 3;
endpackage

// File: rtl/pgc_ctrl.sv
module pgc_ctrl
  import pgc_pkg::*;
#(
  parameter int NUM_IRQ = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wfiReq,
  input  logic               deepQual,
  input  logic [NUM_IRQ-1:0] irqPend,
  input  logic [NUM_IRQ-1:0] irqEnable,
  output pmode_t             modeQ,
  output modeStrobe_t        strobe
);
  logic   irqHit;
  pmode_t modeNext;

  assign irqHit = |(irqPend & irqEnable);

  always_comb begin
    modeNext = modeQ;
    unique case (modeQ)
      MODE_RUN:   if (wfiReq && !irqHit) modeNext = deepQual ? MODE_DEEP : MODE_SLEEP;
      MODE_SLEEP,
      MODE_DEEP:  if (irqHit) modeNext = MODE_RUN;
      default:    modeNext = MODE_RUN;
    endcase
  end

  always_comb begin
    strobe.nextMode   = modeNext;
    strobe.sleepEntry = (modeQ == MODE_RUN) && (modeNext != MODE_RUN);
    strobe.wakeEvent  = (modeQ != MODE_RUN) && (modeNext == MODE_RUN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= MODE_RUN;
    else       modeQ <= modeNext;
  end

  // R6: a request with no enabled interrupt leaves Run
  a_r6_leave_run: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_RUN && wfiReq && !irqHit) |=> (modeQ != MODE_RUN));
  // R7: an enabled pending interrupt keeps Run
  a_r7_hold_run: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_RUN && irqHit) |=> (modeQ == MODE_RUN));
  // R8: wake from any sleep mode
  a_r8_wake: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ != MODE_RUN && irqHit) |=> (modeQ == MODE_RUN));
  // R9: no hop between the two sleep modes
  a_r9_no_hop: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_SLEEP && !irqHit) |=> (modeQ == MODE_SLEEP));
endmodule

// File: rtl/pgc_dp.sv
module pgc_dp
  import pgc_pkg::*;
#(
  parameter int                    NUM_PERIPH = 8,
  parameter logic [NUM_PERIPH-1:0] RUN_RST    = '1,
  parameter logic [NUM_PERIPH-1:0] SLEEP_RST  = '1,
  parameter logic [NUM_PERIPH-1:0] DEEP_RST   = '0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  maskWrEn,
  input  logic [1:0]            maskSel,
  input  logic [NUM_PERIPH-1:0] maskWdata,
  input  modeStrobe_t           strobe,
  output logic [NUM_PERIPH-1:0] periphClkEn,
  output logic                  cpuClkEn,
  output logic                  deepClkSrcReq
);
  logic [NUM_PERIPH-1:0] maskQ [NUM_MODES];

  function automatic logic [NUM_PERIPH-1:0] rstVal(int idx);
    case (idx)
      0:       return RUN_RST;
      1:       return SLEEP_RST;
      default: return DEEP_RST;
    endcase
  endfunction

  for (genvar g = 0; g < NUM_MODES; g++) begin : gMask
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                      maskQ[g] <= rstVal(g);
      else if (maskWrEn && maskSel == 2'(g))          maskQ[g] <= maskWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periphClkEn   <= RUN_RST;
      cpuClkEn      <= 1'b1;
      deepClkSrcReq <= 1'b0;
    end else begin
      unique case (strobe.nextMode)
        MODE_SLEEP: periphClkEn <= maskQ[1];
        MODE_DEEP:  periphClkEn <= maskQ[2];
        default:    periphClkEn <= maskQ[0];
      endcase
      cpuClkEn      <= (strobe.nextMode == MODE_RUN);
      deepClkSrcReq <= (strobe.nextMode == MODE_DEEP);
    end
  end

  // R2: select value 3 touches no mask
  a_r2_sel3_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (maskWrEn && maskSel == 2'd3) |=> ($stable(maskQ[0]) && $stable(maskQ[1]) && $stable(maskQ[2])));
  // R4: entering a sleep mode stops the processor
  a_r4_cpu_stop: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sleepEntry |=> !cpuClkEn);
  // R8: a wake restarts the processor
  a_r8_cpu_start: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wakeEvent |=> (cpuClkEn && !deepClkSrcReq));
endmodule

// File: rtl/pgc_top.sv
module pgc_top
  import pgc_pkg::*;
#(
  parameter int NUM_PERIPH = 8,
  parameter int NUM_IRQ    = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  maskWrEn,
  input  logic [1:0]            maskSel,
  input  logic [NUM_PERIPH-1:0] maskWdata,
  input  logic                  wfiReq,
  input  logic                  deepQual,
  input  logic [NUM_IRQ-1:0]    irqPend,
  input  logic [NUM_IRQ-1:0]    irqEnable,
  output logic [NUM_PERIPH-1:0] periphClkEn,
  output logic                  cpuClkEn,
  output logic                  deepClkSrcReq,
  output logic [1:0]            modeOut
);
  pmode_t      modeQ;
  modeStrobe_t strobe;

  pgc_ctrl #(.NUM_IRQ(NUM_IRQ)) uCtrl (
    .clk(clk), .rstN(rstN), .wfiReq(wfiReq), .deepQual(deepQual),
    .irqPend(irqPend), .irqEnable(irqEnable), .modeQ(modeQ), .strobe(strobe)
  );

  pgc_dp #(.NUM_PERIPH(NUM_PERIPH)) uDp (
    .clk(clk), .rstN(rstN), .maskWrEn(maskWrEn), .maskSel(maskSel),
    .maskWdata(maskWdata), .strobe(strobe), .periphClkEn(periphClkEn),
    .cpuClkEn(cpuClkEn), .deepClkSrcReq(deepClkSrcReq)
  );

  assign modeOut = modeQ;

  // R3: processor enable agrees with the mode held in the control
  a_r3_cpu_run: assert property (@(posedge clk) disable iff (!rstN)
    cpuClkEn == (modeQ == MODE_RUN));
  // R5: deep-source request only while in Deep-Sleep
  a_r5_deep_req: assert property (@(posedge clk) disable iff (!rstN)
    deepClkSrcReq == (modeQ == MODE_DEEP));
endmodule

// File: tb/tb_pgc_top.sv
module tb_pgc_top;
  localparam int NP = 4;
  localparam int NI = 2;

  logic          clk = 0;
  logic          rstN = 0;
  logic          maskWrEn = 0;
  logic [1:0]    maskSel = 0;
  logic [NP-1:0] maskWdata = 0;
  logic          wfiReq = 0;
  logic          deepQual = 0;
  logic [NI-1:0] irqPend = 0;
  logic [NI-1:0] irqEnable = 0;
  logic [NP-1:0] periphClkEn;
  logic          cpuClkEn;
  logic          deepClkSrcReq;
  logic [1:0]    modeOut;

  int total = 0;
  int bad = 0;
  logic [NP-1:0] mRun = '1, mSleep = '1, mDeep = '0;
  logic [1:0] expMode = 0;

  pgc_top #(.NUM_PERIPH(NP), .NUM_IRQ(NI)) dut (
    .clk(clk), .rstN(rstN), .maskWrEn(maskWrEn), .maskSel(maskSel),
    .maskWdata(maskWdata), .wfiReq(wfiReq), .deepQual(deepQual),
    .irqPend(irqPend), .irqEnable(irqEnable), .periphClkEn(periphClkEn),
    .cpuClkEn(cpuClkEn), .deepClkSrcReq(deepClkSrcReq), .modeOut(modeOut)
  );

  always #2 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    logic [NP-1:0] expMask;
    expMask = (expMode == 1) ? mSleep : (expMode == 2) ? mDeep : mRun;
    chk({tag, " mode"}, 32'(modeOut), 32'(expMode));
    chk({tag, " periph"}, 32'(periphClkEn), 32'(expMask));
    chk({tag, " cpu"}, 32'(cpuClkEn), 32'(expMode == 0));
    chk({tag, " deepReq"}, 32'(deepClkSrcReq), 32'(expMode == 2));
  endtask

  task automatic wrMask(logic [1:0] sel, logic [NP-1:0] data);
    maskWrEn = 1; maskSel = sel; maskWdata = data;
    @(negedge clk);
    maskWrEn = 0;
    @(negedge clk);
    if (sel == 0) mRun = data;
    else if (sel == 1) mSleep = data;
    else if (sel == 2) mDeep = data;
  endtask

  task automatic sleepReq(logic deep);
    wfiReq = 1; deepQual = deep;
    @(negedge clk);
    wfiReq = 0; deepQual = 0;
    if (expMode == 0) expMode = deep ? 2'd2 : 2'd1;
  endtask

  task automatic wake(logic [NI-1:0] p, logic [NI-1:0] e);
    irqPend = p; irqEnable = e;
    @(negedge clk);
    irqPend = 0; irqEnable = 0;
    if (expMode != 0 && (p & e) != 0) expMode = 0;
  endtask

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rstN = 1;
    @(negedge clk);
    checkAll("R1 reset");
    sleepReq(0); checkAll("R1 sleep reset mask");
    wake(1, 1);  checkAll("R8 wake");
    sleepReq(1); checkAll("R1 deep reset mask");
    wake(2, 2);  checkAll("R8 wake deep");

    // R2/R3/R4/R5/R6: sweep all mask values
    for (int v = 0; v < 16; v++) begin
      wrMask(0, NP'(v));
      wrMask(1, NP'(v ^ 4'hA));
      wrMask(2, NP'(v ^ 4'h5));
      checkAll("R3 run mask");
      sleepReq(v[0]);
      checkAll(v[0] ? "R5 deep" : "R4 sleep");
      // R9: a second request inside sleep is ignored
      sleepReq(~v[0]);
      checkAll("R9 ignore wfi");
      wake(NI'(1 << (v % NI)), '1);
      checkAll("R6 R8 back to run");
    end

    // R2: select 3 writes nothing
    wrMask(3, 4'h0);
    checkAll("R2 sel3 run");
    sleepReq(0); checkAll("R2 sel3 sleep");
    wake(1, 1);
    sleepReq(1); checkAll("R2 sel3 deep");
    wake(1, 1);

    // R7/R8: every pend/enable combination
    for (int p = 0; p < 4; p++) begin
      for (int e = 0; e < 4; e++) begin
        irqPend = NI'(p); irqEnable = NI'(e);
        wfiReq = 1; deepQual = 0;
        @(negedge clk);
        wfiReq = 0;
        if ((p & e) == 0) expMode = 1;
        checkAll("R7 wfi with irq");
        @(negedge clk);
        irqPend = 0; irqEnable = 0;
        // a non-enabled pend leaves sleep in place (R8)
        checkAll("R8 masked pend");
        wake(1, 1);
        checkAll("R8 return");
      end
    end

    // R2 with R6: mask write coinciding with sleep entry
    maskWrEn = 1; maskSel = 2; maskWdata = 4'h9;
    wfiReq = 1; deepQual = 1;
    @(negedge clk);
    maskWrEn = 0; wfiReq = 0; deepQual = 0;
    expMode = 2;
    checkAll("R2 old mask first edge");
    @(negedge clk);
    mDeep = 4'h9;
    checkAll("R2 new mask second edge");
    wake(3, 3);
    checkAll("R8 final");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule